// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block derives the serial clock of an SPI master from a faster module clock. A 32-bit clock-control word gives it two divider fields and a law-select bit. One law divides by an even integer, 2*(N+1), with an 8-bit N. The other law divides by a power of two, 2^(M+1), with a 4-bit M. The output is a 50% duty-cycle clock that idles low. A one-cycle strobe marks each rising edge and each falling edge, so a shifter running on the module clock can launch and capture data without sampling the divided clock itself.

The core is a three-state machine. `ST_IDLE` holds the output low and the half-period counter at zero. `ST_LOW` and `ST_HIGH` are the two halves of an output period. The transitions are:
- *start* (`ST_IDLE`→`ST_LOW`, when `run` is seen high). The half-period length is loaded from the control word.
- *rise* (`ST_LOW`→`ST_HIGH`, when the counter reaches its terminal count).
- *fall* (`ST_HIGH`→`ST_LOW`, at the terminal count). The half-period length is reloaded here, so this is the period boundary.
- *halt* (from `ST_LOW` or `ST_HIGH` to `ST_IDLE`, whenever `run` is seen low).

The half-period length is N+1 cycles in the linear law and 2^M cycles in the power-of-two law.

Top module: `sclk_divider`

## Requirements
- R1: After reset `sclk`, `rise_stb` and `fall_stb` are all 0.
- R2: When bit 12 of `ctrl_word` is 1, the linear law applies. N is bits [7:0] and each half period lasts N+1 module-clock cycles, so the output period is 2*(N+1) cycles (N=255 gives 512).
- R3: When bit 12 is 0, the power-of-two law applies. M is bits [11:8] and each half period lasts 2^M cycles, so the period is 2^(M+1). Every M from 0 to 15 works, down to a ratio of 65536.
- R4: In the linear law, N=0 makes `sclk` toggle on every module-clock cycle (divide by 2).
- R5: While `run` stays high, each high phase lasts exactly as many cycles as the low phase just before it.
- R6: A new control word written during a period does not alter that period. It is used from the next falling edge of `sclk` onward.
- R7: If `run` is sampled low on a clock edge, `sclk` is low after that edge and the counter restarts from zero. Stopping during a high phase produces one falling edge.
- R8: `rise_stb` is high for exactly the one cycle in which `sclk` has just gone from 0 to 1. `fall_stb` does the same for 1 to 0. The two strobes are never high together.
- R9: Bits [31:13] of `ctrl_word` have no effect. The divider field of the law not selected also has no effect.
- R10: If `run` is first seen high at clock edge e0, the first rising edge of `sclk` comes at edge e0 + H, where H is the half-period length. Falling edges follow at e0 + 2H, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to generate the clock, low to idle |
| ctrl_word | input | 32 | Clock-control word: [7:0] N, [11:8] M, [12] law select |
| sclk | output | 1 | Divided serial clock, idle low |
| rise_stb | output | 1 | One-cycle pulse with each rising edge of `sclk` |
| fall_stb | output | 1 | One-cycle pulse with each falling edge of `sclk` |

## Verification
The linear law is tried with N = 0, 3, 5 and 255.
- N = 0 checks the toggle-every-cycle limit.
- N = 3 checks the plain N+1 half period.
- N = 255 checks that the counter does not wrap at the top of the field.

The power-of-two law is tried with M = 0, 3, 5 and 15.
- M = 3 checks that the law uses 2^M and not M+1.
- M = 15 checks that the counter is wide enough for a 65536 ratio.
- Control words with their high bits and the unselected field set to junk show whether those bits leak into the period.

A control change written during a high phase checks that the new period begins only at the next fall. Dropping `run` during a high phase, and then restarting, checks the forced fall, the idle hold and the timing of the first rise.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

    localparam int SD_CTRL_W   = 32;
    localparam int SD_LIN_W    = 8;
    localparam int SD_POW_W    = 4;
    localparam int SD_POW_LSB  = 8;
    localparam int SD_MODE_BIT = 12;

    // Width that holds the largest half period of either law.
    function automatic int sd_half_w(input int lin_w, input int pow_w);
        int pw;
        pw = 2 ** pow_w;
        return (lin_w + 1 > pw) ? lin_w + 1 : pw;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } sd_state_t;

endpackage

// File: rtl/sclkdiv_decode.sv
module sclkdiv_decode #(
    parameter int CTRL_W   = 32,
    parameter int LIN_W    = 8,
    parameter int POW_W    = 4,
    parameter int POW_LSB  = 8,
    parameter int MODE_BIT = 12,
    parameter int HALF_W   = 16
) (
    input  logic [CTRL_W-1:0] ctrl,
    output logic [HALF_W-1:0] half
);

    logic [LIN_W-1:0]  lin_field;
    logic [POW_W-1:0]  pow_field;
    logic [HALF_W-1:0] lin_half;
    logic [HALF_W-1:0] pow_half;
    logic              unused_ctrl_par;

    assign lin_field = ctrl[LIN_W-1:0];
    assign pow_field = ctrl[POW_LSB +: POW_W];

    // Linear law: half period of N+1 cycles.
    assign lin_half = {{(HALF_W-LIN_W){1'b0}}, lin_field} + HALF_W'(1);
    // Power-of-two law: half period of 2^M cycles.
    assign pow_half = HALF_W'(1) << pow_field;

    assign half = ctrl[MODE_BIT] ? lin_half : pow_half;

    // The remaining control bits are deliberately ignored.
    assign unused_ctrl_par = ^ctrl;

endmodule

// File: rtl/sclkdiv_phase_cnt.sv
module sclkdiv_phase_cnt #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [HALF_W-1:0] half,
    output logic              term
);

    logic [HALF_W-1:0] cnt;

    assign term = (cnt == half - HALF_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || term) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + HALF_W'(1);
        end
    end

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
    import sclkdiv_pkg::*;
#(
    parameter int CTRL_W   = SD_CTRL_W,
    parameter int LIN_W    = SD_LIN_W,
    parameter int POW_W    = SD_POW_W,
    parameter int POW_LSB  = SD_POW_LSB,
    parameter int MODE_BIT = SD_MODE_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              sclk,
    output logic              rise_stb,
    output logic              fall_stb
);

    localparam int HALF_W = sd_half_w(LIN_W, POW_W);

    sd_state_t         state;
    sd_state_t         state_nx;
    logic [HALF_W-1:0] half_dec;
    logic [HALF_W-1:0] half_q;
    logic              term;
    logic              cnt_clr;
    logic              load_half;

    sclkdiv_decode #(
        .CTRL_W   (CTRL_W),
        .LIN_W    (LIN_W),
        .POW_W    (POW_W),
        .POW_LSB  (POW_LSB),
        .MODE_BIT (MODE_BIT),
        .HALF_W   (HALF_W)
    ) u_decode (
        .ctrl (ctrl_word),
        .half (half_dec)
    );

    assign cnt_clr = (state == ST_IDLE) || !run;

    sclkdiv_phase_cnt #(
        .HALF_W (HALF_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .half  (half_q),
        .term  (term)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions: start, rise, fall, halt.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = run ? ST_LOW : ST_IDLE;
            ST_LOW:  state_nx = !run ? ST_IDLE : (term ? ST_HIGH : ST_LOW);
            ST_HIGH: state_nx = !run ? ST_IDLE : (term ? ST_LOW : ST_HIGH);
            default: state_nx = ST_IDLE;
        endcase
    end

    // Half-period length is sampled on start and at each period boundary.
    assign load_half = run && ((state == ST_IDLE) ||
                               (state == ST_HIGH && term));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= HALF_W'(1);
        end else if (load_half) begin
            half_q <= half_dec;
        end
    end

    // Registered outputs follow the state transition of the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk     <= 1'b0;
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            sclk     <= (state_nx == ST_HIGH);
            rise_stb <= (state != ST_HIGH) && (state_nx == ST_HIGH);
            fall_stb <= (state == ST_HIGH) && (state_nx != ST_HIGH);
        end
    end

endmodule

// File: rtl/sclkdiv_checker.sv
module sclkdiv_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic sclk,
    input logic rise_stb,
    input logic fall_stb
);

    logic        sclk_q;
    logic        run_q;
    logic        clean;
    logic        pair_ok;
    logic [31:0] phase_cnt;
    logic [31:0] low_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            run_q     <= 1'b0;
            clean     <= 1'b0;
            pair_ok   <= 1'b0;
            phase_cnt <= 32'd0;
            low_len   <= 32'd0;
        end else begin
            sclk_q <= sclk;
            run_q  <= run;
            if (sclk != sclk_q)
                phase_cnt <= 32'd1;
            else if (phase_cnt != 32'hFFFF_FFFF)
                phase_cnt <= phase_cnt + 32'd1;
            if (!run_q)
                clean <= 1'b0;
            else if (sclk_q && !sclk)
                clean <= 1'b1;
            if (!sclk_q && sclk) begin
                low_len <= phase_cnt;
                pair_ok <= clean;
            end else if (!run_q) begin
                pair_ok <= 1'b0;
            end
        end
    end

    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);

    a_r7_no_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rise_stb);

    a_r8_rose_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> rise_stb);

    a_r8_fell_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> fall_stb);

    a_r8_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (sclk && !sclk_q));

    a_r8_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> (!sclk && sclk_q));

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_stb, fall_stb}));

    a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);

    a_r5_duty: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && !sclk && run_q && pair_ok) |-> (phase_cnt == low_len));

endmodule

bind sclk_divider sclkdiv_checker u_sclkdiv_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .sclk     (sclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/tb_sclk_divider.sv
module tb_sclk_divider;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run;
    logic [31:0] ctrl;
    logic        sclk;
    logic        rise_stb;
    logic        fall_stb;

    always #5 clk = ~clk;

    sclk_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .ctrl_word (ctrl),
        .sclk      (sclk),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );

    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    exp_cyc[$];
    bit    exp_rise[$];
    logic  sclk_prev;
    int    pop_c;
    bit    pop_r;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (%s): cycle %0d, expected end before 190000", cur_req, cyc);
            summary();
            $finish;
        end
    end

    // Monitor: pops expected edges and compares them with observed ones.
    always @(negedge clk) begin
        if (!rst_n) begin
            sclk_prev = 1'b0;
        end else begin
            if (sclk !== sclk_prev) begin
                n_chk++;
                if (exp_cyc.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s: unexpected edge to %0b at cycle %0d, expected none",
                             cur_req, sclk, cyc);
                end else begin
                    pop_c = exp_cyc.pop_front();
                    pop_r = exp_rise.pop_front();
                    if (pop_c != cyc || pop_r != sclk) begin
                        n_fail++;
                        $display("FAIL %s: edge to %0b at cycle %0d, expected edge to %0b at %0d",
                                 cur_req, sclk, cyc, pop_r, pop_c);
                    end
                end
                // R8: strobe matching the direction of the edge
                n_chk++;
                if (rise_stb !== sclk || fall_stb !== !sclk) begin
                    n_fail++;
                    $display("FAIL R8: strobes rise=%0b fall=%0b, expected rise=%0b fall=%0b",
                             rise_stb, fall_stb, sclk, !sclk);
                end
            end else if (rise_stb || fall_stb) begin
                n_chk++;
                n_fail++;
                $display("FAIL R8: strobe rise=%0b fall=%0b with no edge, expected 0 0",
                         rise_stb, fall_stb);
            end
            sclk_prev = sclk;
        end
    end

    task automatic push(input int c, input bit r);
        exp_cyc.push_back(c);
        exp_rise.push_back(r);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic start(input logic [31:0] c, output int e0);
        @(negedge clk);
        ctrl = c;
        run  = 1'b1;
        e0   = cyc + 1;
    endtask

    task automatic drain_check();
        n_chk++;
        if (exp_cyc.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d expected edges missing, expected 0", cur_req, exp_cyc.size());
            exp_cyc.delete();
            exp_rise.delete();
        end
    endtask

    // Driver: pushes n full periods of half-length h, then stops.
    task automatic run_case(input string tag, input logic [31:0] c, input int h, input int n);
        int e0;
        int last;
        cur_req = tag;
        start(c, e0);
        last = e0;
        for (int k = 0; k < n; k++) begin
            push(last + h, 1'b1);
            push(last + 2 * h, 1'b0);
            last = last + 2 * h;
        end
        wait_until(last);
        run = 1'b0;
        repeat (4) @(negedge clk);
        drain_check();
    endtask

    initial begin
        int e0;
        rst_n = 1'b0;
        run   = 1'b0;
        ctrl  = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        n_chk++;
        if (sclk !== 1'b0 || rise_stb !== 1'b0 || fall_stb !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: sclk=%0b rise=%0b fall=%0b, expected 0 0 0", sclk, rise_stb, fall_stb);
        end
        repeat (2) @(negedge clk);

        run_case("R4 R10", 32'h0000_1000, 1, 4);
        run_case("R2 R5", 32'h0000_1003, 4, 3);
        run_case("R9 R2", 32'hDEAD_3A05, 6, 2);
        run_case("R3", 32'h0000_0000, 1, 3);
        run_case("R3 R5", 32'h0000_0300, 8, 2);
        run_case("R9 R3", 32'hFFFF_E5AB, 32, 2);

        // R6: control change during the high phase waits for the period boundary
        cur_req = "R6";
        start(32'h0000_1003, e0);
        push(e0 + 4, 1'b1);
        push(e0 + 8, 1'b0);
        push(e0 + 10, 1'b1);
        push(e0 + 12, 1'b0);
        push(e0 + 14, 1'b1);
        push(e0 + 16, 1'b0);
        wait_until(e0 + 5);
        ctrl = 32'h0000_1001;
        wait_until(e0 + 16);
        run = 1'b0;
        repeat (4) @(negedge clk);
        drain_check();

        // R7: stop during the high phase forces one fall, then holds low
        cur_req = "R7";
        start(32'h0000_1003, e0);
        push(e0 + 4, 1'b1);
        push(e0 + 6, 1'b0);
        wait_until(e0 + 5);
        run = 1'b0;
        wait_until(e0 + 20);
        drain_check();
        n_chk++;
        if (sclk !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: sclk=%0b while stopped, expected 0", sclk);
        end

        // R10 restart after a stop: counter restarted from zero
        run_case("R10 R7", 32'h0000_1007, 8, 1);
        run_case("R3 max", 32'h0000_0F00, 32768, 1);
        run_case("R2 max", 32'h0000_10FF, 256, 1);

        summary();
        $finish;
    end

endmodule